// File: doc/BRIEF.md
# 16-bit Memory Operand Address Generator

This block works out where a 16-bit-mode memory operand lives. A decoder hands it the two addressing fields of the operand byte (mode and register/memory select), the current values of the four 16-bit address registers (BX, BP, SI, DI), the data-segment and stack-segment bases, and an optional override base. It returns the 16-bit effective offset and the linear address. When the encoding carries a displacement, the block pulls the bytes from a valid/ready byte stream, low byte first.

A request is taken on a one-cycle `start` while the block is idle. The operand fields and register values are captured on that edge. Displacement bytes are then consumed one per handshake. A one-cycle `done` marks the point where `ea_offset` and `ea_linear` are valid. Both results are held until the next accepted request. Register-direct encodings (mode 3) are not memory operands, so the block refuses them.

Top module: `ea16_agen`

## Requirements
- R1: For mode 0 with select other than 6, the offset is the register term with no displacement: select 0=BX+SI, 1=BX+DI, 2=BP+SI, 3=BP+DI, 4=SI, 5=DI, 7=BX. In modes 1 and 2, select 6 means BP.
- R2: Mode 0 with select 6 fetches two displacement bytes, low byte first. The offset is that 16-bit value alone, and the default segment is the data segment.
- R3: Mode 1 fetches one displacement byte, sign-extends it to 16 bits, and adds it to the register term.
- R4: Mode 2 fetches two displacement bytes, low byte first, and adds the 16-bit value to the register term.
- R5: Without override, the stack-segment base is used for select 2 and 3 in any mode, and for select 6 in modes 1 and 2. Every other combination uses the data-segment base.
- R6: With `ovr_en` high at start, `ovr_base` replaces the default base. The offset is unaffected.
- R7: The offset sum wraps modulo 2^16. `ea_linear` is the chosen base plus the zero-extended offset, modulo 2^ADDR_W.
- R8: `done` is high for exactly one cycle. It comes in the cycle after the last displacement byte is accepted, or in the cycle after start when no byte is needed. `disp_ready` is high only while a byte is awaited, and never together with `done`.
- R9: A start with mode 3 is ignored. No `done` follows, `disp_ready` stays low, and the held results do not change.
- R10: Start is ignored unless the block is idle, including in the `done` cycle. Bytes offered while `disp_ready` is low are not consumed. While idle, the results hold.
- R11: After reset, `done`, `disp_ready`, `ea_offset` and `ea_linear` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| ea_mod | input | 2 | Mode field |
| ea_rm | input | 3 | Register/memory select field |
| val_bx | input | 16 | BX value |
| val_bp | input | 16 | BP value |
| val_si | input | 16 | SI value |
| val_di | input | 16 | DI value |
| ds_base | input | ADDR_W | Data-segment base |
| ss_base | input | ADDR_W | Stack-segment base |
| ovr_en | input | 1 | Use override base |
| ovr_base | input | ADDR_W | Override segment base |
| disp_valid | input | 1 | Displacement byte offered |
| disp_byte | input | 8 | Displacement byte |
| disp_ready | output | 1 | Block is waiting for a displacement byte |
| ea_offset | output | 16 | Effective offset |
| ea_linear | output | ADDR_W | Linear address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse and a request can land in the same cycle. A start raised exactly when `done` is high must be dropped, because the block is not idle until the cycle after. The bench provokes this by raising `start` with a different operand in the `done` cycle of a displacement-free request. It then expects no further `done` and unchanged results. The second overlap is a displacement byte offered while `disp_ready` is low, either idle or in the `done` cycle. The bench presents such bytes and then checks that the next request computes from the bytes it is given afterwards.

// File: rtl/ea16_pkg.sv
package ea16_pkg;

  typedef enum logic [1:0] {
    EA_IDLE = 2'd0,
    EA_LO   = 2'd1,
    EA_HI   = 2'd2,
    EA_DONE = 2'd3
  } ea_state_t;

  // register term selected by the rm field; rm=6 in mode 0 has no register
  function automatic logic [15:0] reg_term(input logic [1:0] md, input logic [2:0] rm,
                                           input logic [15:0] bx, input logic [15:0] bp,
                                           input logic [15:0] si, input logic [15:0] di);
    logic [15:0] t;
    case (rm)
      3'd0: t = bx + si;
      3'd1: t = bx + di;
      3'd2: t = bp + si;
      3'd3: t = bp + di;
      3'd4: t = si;
      3'd5: t = di;
      3'd6: t = (md == 2'd0) ? 16'd0 : bp;
      default: t = bx;
    endcase
    return t;
  endfunction

  function automatic logic uses_stack(input logic [1:0] md, input logic [2:0] rm);
    return (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && (md != 2'd0));
  endfunction

  function automatic logic [1:0] disp_count(input logic [1:0] md, input logic [2:0] rm);
    logic [1:0] n;
    case (md)
      2'd1:    n = 2'd1;
      2'd2:    n = 2'd2;
      2'd0:    n = (rm == 3'd6) ? 2'd2 : 2'd0;
      default: n = 2'd0;
    endcase
    return n;
  endfunction

  function automatic logic [15:0] widen_disp(input logic [1:0] md, input logic [7:0] lo,
                                             input logic [7:0] hi);
    return (md == 2'd1) ? {{8{lo[7]}}, lo} : {hi, lo};
  endfunction

endpackage

// File: rtl/ea16_ctrl.sv
module ea16_ctrl
  import ea16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_mod,
  input  logic [2:0] op_rm,
  input  logic       disp_valid,
  output logic       cap_en,
  output logic       lo_we,
  output logic       hi_we,
  output logic       disp_ready,
  output logic       done,
  output logic       idle
);
  ea_state_t   st;
  logic        two_q;
  logic        take;
  logic [1:0]  need;

  assign need       = disp_count(op_mod, op_rm);
  assign idle       = (st == EA_IDLE);
  assign done       = (st == EA_DONE);
  assign disp_ready = (st == EA_LO) || (st == EA_HI);
  assign take       = disp_valid && disp_ready;
  assign cap_en     = idle && start && (op_mod != 2'd3);
  assign lo_we      = take && (st == EA_LO);
  assign hi_we      = take && (st == EA_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= EA_IDLE;
      two_q <= 1'b0;
    end else begin
      case (st)
        EA_IDLE: if (cap_en) begin
          two_q <= (need == 2'd2);
          st    <= (need == 2'd0) ? EA_DONE : EA_LO;
        end
        EA_LO:   if (take) st <= two_q ? EA_HI : EA_DONE;
        EA_HI:   if (take) st <= EA_DONE;
        default: st <= EA_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea16_disp.sv
module ea16_disp
  import ea16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        lo_we,
  input  logic        hi_we,
  input  logic [7:0]  byte_in,
  input  logic [1:0]  cap_mod,
  output logic [15:0] disp16
);
  logic [7:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= byte_in;
      if (hi_we) hi_q <= byte_in;
    end
  end

  assign disp16 = widen_disp(cap_mod, lo_q, hi_q);
endmodule

// File: rtl/ea16_sum.sv
module ea16_sum
  import ea16_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        md,
  input  logic [2:0]        rm,
  input  logic [15:0]       bx,
  input  logic [15:0]       bp,
  input  logic [15:0]       si,
  input  logic [15:0]       di,
  input  logic [15:0]       disp16,
  input  logic [ADDR_W-1:0] ds_b,
  input  logic [ADDR_W-1:0] ss_b,
  input  logic              ovr,
  input  logic [ADDR_W-1:0] ovr_b,
  output logic [15:0]       offset,
  output logic [ADDR_W-1:0] linear
);
  localparam int PAD_W = ADDR_W - 16;
  logic [ADDR_W-1:0] base_sel;

  assign offset   = reg_term(md, rm, bx, bp, si, di) + disp16;
  assign base_sel = ovr ? ovr_b : (uses_stack(md, rm) ? ss_b : ds_b);
  assign linear   = base_sel + {{PAD_W{1'b0}}, offset};
endmodule

// File: rtl/ea16_agen.sv
module ea16_agen
  import ea16_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        ea_mod,
  input  logic [2:0]        ea_rm,
  input  logic [15:0]       val_bx,
  input  logic [15:0]       val_bp,
  input  logic [15:0]       val_si,
  input  logic [15:0]       val_di,
  input  logic [ADDR_W-1:0] ds_base,
  input  logic [ADDR_W-1:0] ss_base,
  input  logic              ovr_en,
  input  logic [ADDR_W-1:0] ovr_base,
  input  logic              disp_valid,
  input  logic [7:0]        disp_byte,
  output logic              disp_ready,
  output logic [15:0]       ea_offset,
  output logic [ADDR_W-1:0] ea_linear,
  output logic              done
);
  logic              cap_en, lo_we, hi_we, ctl_idle;
  logic [1:0]        m_q;
  logic [2:0]        r_q;
  logic [15:0]       bx_q, bp_q, si_q, di_q, disp16;
  logic [ADDR_W-1:0] ds_q, ss_q, ob_q;
  logic              ov_q;

  ea16_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_mod(ea_mod), .op_rm(ea_rm),
    .disp_valid(disp_valid), .cap_en(cap_en), .lo_we(lo_we), .hi_we(hi_we),
    .disp_ready(disp_ready), .done(done), .idle(ctl_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0; r_q <= '0;
      bx_q <= '0; bp_q <= '0; si_q <= '0; di_q <= '0;
      ds_q <= '0; ss_q <= '0; ob_q <= '0; ov_q <= 1'b0;
    end else if (cap_en) begin
      m_q <= ea_mod; r_q <= ea_rm;
      bx_q <= val_bx; bp_q <= val_bp; si_q <= val_si; di_q <= val_di;
      ds_q <= ds_base; ss_q <= ss_base; ob_q <= ovr_base; ov_q <= ovr_en;
    end
  end

  ea16_disp u_disp (
    .clk(clk), .rst_n(rst_n), .clr(cap_en), .lo_we(lo_we), .hi_we(hi_we),
    .byte_in(disp_byte), .cap_mod(m_q), .disp16(disp16)
  );

  ea16_sum #(.ADDR_W(ADDR_W)) u_sum (
    .md(m_q), .rm(r_q), .bx(bx_q), .bp(bp_q), .si(si_q), .di(di_q),
    .disp16(disp16), .ds_b(ds_q), .ss_b(ss_q), .ovr(ov_q), .ovr_b(ob_q),
    .offset(ea_offset), .linear(ea_linear)
  );
endmodule

// File: rtl/ea16_agen_chk.sv
module ea16_agen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [1:0]        ea_mod,
  input logic              disp_ready,
  input logic              done,
  input logic              idle,
  input logic [15:0]       ea_offset,
  input logic [ADDR_W-1:0] ea_linear
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_ready && done)); // R8
  AST_MOD3_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && ea_mod == 2'd3) |=> (idle && !done && !disp_ready)); // R9
  AST_START_IN_DONE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (idle && !disp_ready)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> ($stable(ea_offset) && $stable(ea_linear))); // R10
endmodule

bind ea16_agen ea16_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ea_mod(ea_mod),
  .disp_ready(disp_ready), .done(done), .idle(ctl_idle),
  .ea_offset(ea_offset), .ea_linear(ea_linear)
);

// File: tb/sim_ea16_agen.sv
`timescale 1ns/1ps
module sim_ea16_agen;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0, start = 0, ovr_en = 0, disp_valid = 0;
  logic [1:0] ea_mod = 0;
  logic [2:0] ea_rm = 0;
  logic [15:0] val_bx = 0, val_bp = 0, val_si = 0, val_di = 0;
  logic [AW-1:0] ds_base = 0, ss_base = 0, ovr_base = 0;
  logic [7:0] disp_byte = 0;
  logic disp_ready, done;
  logic [15:0] ea_offset;
  logic [AW-1:0] ea_linear;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] q_off[$];
  logic [AW-1:0] q_lin[$];
  string q_tag[$];

  always #10 clk = ~clk;

  ea16_agen #(.ADDR_W(AW)) u0 (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare results against the scoreboard
  always @(posedge clk) begin
    #5;
    if (rst_n && done) begin
      if (q_off.size() == 0) check(0, "R10 unexpected done", 1, 0);
      else begin
        logic [15:0] eo; logic [AW-1:0] el; string t;
        eo = q_off.pop_front(); el = q_lin.pop_front(); t = q_tag.pop_front();
        check(ea_offset == eo, {t, " offset"}, ea_offset, eo);
        check(ea_linear == el, {t, " linear"}, ea_linear, el);
      end
    end
  end

  function automatic int nbytes(input logic [1:0] md, input logic [2:0] rm);
    if (md == 2'd1) return 1;
    if (md == 2'd2 || (md == 2'd0 && rm == 3'd6)) return 2;
    return 0;
  endfunction

  task automatic run_op(input logic [1:0] md, input logic [2:0] rm,
                        input logic [15:0] bx, input logic [15:0] bp,
                        input logic [15:0] si, input logic [15:0] di,
                        input logic [AW-1:0] dsb, input logic [AW-1:0] ssb,
                        input logic ov, input logic [AW-1:0] ob,
                        input logic [7:0] b0, input logic [7:0] b1,
                        input int gap, input string tag);
    logic [15:0] regs, dsp, off;
    logic [AW-1:0] base;
    int n;
    if (rm[2]) begin
      case (rm[1:0])
        2'd0: regs = si;
        2'd1: regs = di;
        2'd2: regs = (md == 0) ? 16'h0 : bp;
        default: regs = bx;
      endcase
    end else regs = (rm[1] ? bp : bx) + (rm[0] ? di : si);
    n = nbytes(md, rm);
    dsp = (n == 1) ? {{8{b0[7]}}, b0} : (n == 2) ? {b1, b0} : 16'h0;
    off = regs + dsp;
    base = ov ? ob : ((rm == 2 || rm == 3 || (rm == 6 && md != 0)) ? ssb : dsb);
    q_off.push_back(off); q_lin.push_back(base + AW'(off)); q_tag.push_back(tag);
    @(negedge clk);
    ea_mod = md; ea_rm = rm; val_bx = bx; val_bp = bp; val_si = si; val_di = di;
    ds_base = dsb; ss_base = ssb; ovr_en = ov; ovr_base = ob; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) begin
        check(disp_ready == 1 && done == 0, "R8 waiting for byte", disp_ready, 1);
        @(negedge clk);
      end
      disp_valid = 1; disp_byte = (k == 0) ? b0 : b1;
      @(negedge clk);
      disp_valid = 0;
    end
    check(done == 1, "R8 done timing", done, 1);
    check(disp_ready == 0, "R8 ready low at done", disp_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0 && disp_ready == 0, "R11 reset ctrl", {done, disp_ready}, 0);
    check(ea_offset == 0 && ea_linear == 0, "R11 reset results", ea_linear, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 register-only forms
    run_op(0, 0, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 8'h55, 8'h66, 0, "R1 bx+si");
    @(negedge clk);
    run_op(0, 5, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 8'h55, 8'h66, 0, "R1 di");
    @(negedge clk);
    run_op(0, 7, 16'h1234, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 0, 0, 0, "R1 bx");
    @(negedge clk);
    // R5 stack default via bp+di
    run_op(0, 3, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 0, 0, 0, "R5 bp+di stack");
    @(negedge clk);
    // R2 direct displacement, bytes offered before start are not consumed (R10)
    disp_valid = 1; disp_byte = 8'hEE;
    repeat (2) @(negedge clk);
    disp_valid = 0;
    run_op(0, 6, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 8'h34, 8'h12, 2, "R2 direct");
    @(negedge clk);
    // R3 sign-extended byte, negative and positive, bp in mode 1 uses stack (R5)
    run_op(1, 6, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 8'h80, 8'h00, 1, "R3 bp-128 stack");
    @(negedge clk);
    run_op(1, 4, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 8'h7F, 8'h00, 0, "R3 si+127");
    @(negedge clk);
    // R4 16-bit displacement
    run_op(2, 1, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 0, 0, 8'hCD, 8'hAB, 3, "R4 bx+di+abcd");
    @(negedge clk);
    // R6 override on a stack form
    run_op(2, 2, 16'h1000, 16'h2000, 16'h0030, 16'h0400, 32'h10000, 32'h20000, 1, 32'h90000, 8'h01, 8'h00, 0, "R6 override");
    @(negedge clk);
    // R7 wrap of offset and of linear address
    run_op(0, 0, 16'hFFF0, 0, 16'h0020, 0, 32'hFFFF_FFF8, 0, 0, 0, 0, 0, 0, "R7 wrap");
    @(negedge clk);
    // R9 mode 3 ignored
    ea_mod = 3; ea_rm = 0; val_bx = 16'h4444; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) begin
      check(done == 0 && disp_ready == 0, "R9 mode3 no activity", {done, disp_ready}, 0);
      @(negedge clk);
    end
    check(ea_offset == 16'h0010, "R9 results held", ea_offset, 16'h0010);
    // R10 start in the done cycle is dropped; byte offered in done cycle ignored
    run_op(0, 4, 0, 0, 16'h0777, 0, 32'h100, 0, 0, 0, 0, 0, 0, "R10 base op");
    ea_mod = 2; ea_rm = 0; start = 1; disp_valid = 1; disp_byte = 8'h99;
    @(negedge clk);
    start = 0; disp_valid = 0;
    repeat (3) begin
      check(done == 0 && disp_ready == 0, "R10 start in done dropped", {done, disp_ready}, 0);
      @(negedge clk);
    end
    check(ea_offset == 16'h0777, "R10 results held", ea_offset, 16'h0777);
    run_op(1, 7, 16'h0100, 0, 0, 0, 32'h0, 0, 0, 0, 8'h02, 0, 0, "R10 next op uses own byte");
    repeat (3) @(negedge clk);
    check(q_off.size() == 0, "R8 all results seen", q_off.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule